// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog counter driven by a slow tick-enable pulse. Software services it through a single 32-bit control word. The word carries a reload count, a run/enable command bit and a 7-bit key. Once the watchdog is running, a rewrite only takes effect if its key is the bitwise inverse of the key stored by the previous accepted write. A stray or repeated write therefore cannot keep a hung system alive.

Expiry escalates in two stages. The first timeout raises a non-maskable interrupt and reloads a short grace count, and counting continues. A second timeout without an accepted write in between raises a system reset request. The reset request stays high until the block itself is reset. The remaining tick count is visible on an output so that the state of the counter can be observed.

Top module: `wdg_keyed_watchdog`

## Requirements
- R1: The control word holds the count in bits [7:0], the run command in bit 8 and the key in bits [15:9]. An accepted write loads count_o with its count field, visible in the cycle after the write.
- R2: While the stored command bit is 1, a write is accepted only if its key equals the bitwise inverse of the stored key. Any other write leaves count_o, nmi_o and the stored word unchanged. While the stored command bit is 0, every key is accepted.
- R3: A count field of zero loads 256 ticks.
- R4: An accepted write clears nmi_o and reloads the counter. It starts counting if bit 8 is 1. If bit 8 is 0 it stops counting, and count_o then holds while ticks arrive.
- R5: On the first expiry (a tick while the count is 1), nmi_o rises in the next cycle, count_o reloads to GRACE_TICKS (default 1) and counting continues.
- R6: A further expiry with no accepted write since the first one raises rst_req_o and stops the counter at 0.
- R7: The count drops by exactly one on each cycle where tick_i is high and the counter runs. It does not change on any other cycle without a write.
- R8: Once rst_req_o is high, it stays high until rst_ni is asserted, even if an accepted write arrives.
- R9: After reset, nmi_o, rst_req_o and count_o are 0 and the stored word is cleared, so the first write is accepted whatever its key.
- R10: When an accepted write and an expiring tick fall in the same cycle, the write takes effect and no escalation happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word to write |
| tick_i | input | 1 | Slow tick enable, one cycle per tick |
| nmi_o | output | 1 | Non-maskable interrupt, first-stage expiry |
| rst_req_o | output | 1 | Sticky system reset request, second-stage expiry |
| count_o | output | 9 | Remaining ticks before expiry |

## Verification
The counter is driven with tick bursts separated by idle cycles. This separates decrementing on ticks from drift on plain clock cycles, and the bursts are sized to stop one tick short of expiry and then exactly on it. The key gate is tried with a repeated key, the inverted key and arbitrary keys while stopped. This tells rejection apart from acceptance through whether count_o reloads. Escalation is tried as a single expiry then service, a double expiry, and a write that coincides with an expiring tick. These show the grace reload, the sticky reset request and the priority of the write.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    STG_ARMED = 2'd0,
    STG_GRACE = 2'd1,
    STG_FIRED = 2'd2
  } wdg_stage_e;
endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int KEY_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              accept_o,
  output logic              run_cmd_o,
  output logic [CNT_W-1:0]  cnt_field_o
);
  localparam int EN_BIT  = CNT_W;
  localparam int KEY_LSB = CNT_W + 1;

  logic [DATA_W-1:0] ctrl_q;
  logic [KEY_W-1:0]  stored_key, new_key;
  logic              key_ok;

  assign stored_key  = ctrl_q[KEY_LSB +: KEY_W];
  assign new_key     = wr_data_i[KEY_LSB +: KEY_W];
  // running watchdog demands the inverted key
  assign key_ok      = !ctrl_q[EN_BIT] || (new_key == ~stored_key);
  assign accept_o    = wr_en_i && key_ok;
  assign run_cmd_o   = wr_data_i[EN_BIT];
  assign cnt_field_o = wr_data_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (accept_o) ctrl_q <= wr_data_i;
  end

  // R2
  rejected_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !accept_o) |=> $stable(ctrl_q));
endmodule

// File: rtl/wdg_tick_counter.sv
module wdg_tick_counter #(
  parameter int CNT_W       = 8,
  parameter int GRACE_TICKS = 1,
  localparam int CT_W       = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_field_i,
  input  logic             run_cmd_i,
  input  logic             tick_i,
  input  logic             halt_i,
  output logic             expire_o,
  output logic [CT_W-1:0]  count_o
);
  localparam logic [CT_W-1:0] FULL_V  = CT_W'(1) << CNT_W;
  localparam logic [CT_W-1:0] GRACE_V = CT_W'(GRACE_TICKS);

  logic            run_q;
  logic [CT_W-1:0] cnt_q;
  logic [CT_W-1:0] load_v;

  assign load_v   = (load_field_i == '0) ? FULL_V : {1'b0, load_field_i};
  // a write in the same cycle wins over expiry
  assign expire_o = run_q && tick_i && (cnt_q == CT_W'(1)) && !load_i;
  assign count_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_v;
      run_q <= run_cmd_i;
    end else if (expire_o) begin
      if (halt_i) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else begin
        cnt_q <= GRACE_V;
      end
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - CT_W'(1);
    end
  end

  initial begin
    assert (GRACE_TICKS >= 1 && GRACE_TICKS < (1 << CT_W));
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  // R5
  run_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q != '0));
endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate
  import wdg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic expire_i,
  output logic halt_o,
  output logic nmi_o,
  output logic rst_req_o
);
  wdg_stage_e stage_q;
  logic       nmi_q, rst_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= STG_ARMED;
      nmi_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else if (accept_i) begin
      stage_q <= STG_ARMED;
      nmi_q   <= 1'b0;
    end else if (expire_i) begin
      if (stage_q == STG_ARMED) begin
        stage_q <= STG_GRACE;
        nmi_q   <= 1'b1;
      end else begin
        stage_q   <= STG_FIRED;
        rst_req_q <= 1'b1;
      end
    end
  end

  assign halt_o    = (stage_q != STG_ARMED);
  assign nmi_o     = nmi_q;
  assign rst_req_o = rst_req_q;

  // R8
  rst_req_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |=> rst_req_q);
  // R6
  rst_after_nmi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_q) |-> $past(nmi_q));
endmodule

// File: rtl/wdg_keyed_watchdog.sv
module wdg_keyed_watchdog #(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 8,
  parameter int KEY_W       = 7,
  parameter int GRACE_TICKS = 1,
  localparam int CT_W       = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  output logic              nmi_o,
  output logic              rst_req_o,
  output logic [CT_W-1:0]   count_o
);
  logic             accept, run_cmd, expire, halt;
  logic [CNT_W-1:0] cnt_field;

  wdg_key_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_W(KEY_W)) u_gate (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .accept_o(accept), .run_cmd_o(run_cmd), .cnt_field_o(cnt_field)
  );

  wdg_tick_counter #(.CNT_W(CNT_W), .GRACE_TICKS(GRACE_TICKS)) u_cnt (
    .clk_i, .rst_ni, .load_i(accept), .load_field_i(cnt_field),
    .run_cmd_i(run_cmd), .tick_i, .halt_i(halt),
    .expire_o(expire), .count_o
  );

  wdg_escalate u_esc (
    .clk_i, .rst_ni, .accept_i(accept), .expire_i(expire),
    .halt_o(halt), .nmi_o, .rst_req_o
  );

  initial begin
    assert (DATA_W >= CNT_W + 1 + KEY_W);
  end

  // R4
  service_clears_nmi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !nmi_o);
endmodule

// File: tb/wdg_keyed_watchdog_test.sv
`timescale 1ns/1ps
module wdg_keyed_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tick = 1'b0;
  logic        nmi, rst_req;
  logic [8:0]  count;
  int          n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  wdg_keyed_watchdog uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tick_i(tick), .nmi_o(nmi), .rst_req_o(rst_req), .count_o(count)
  );

  function automatic logic [31:0] word(input logic [6:0] key, input logic cmd,
                                       input logic [7:0] cnt);
    return {16'h0, key, cmd, cnt};
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk) begin wr_en = 1'b1; wr_data = w; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R9 nmi after reset", nmi, 0);
    check("R9 rst_req after reset", rst_req, 0);
    check("R9 count after reset", count, 0);
  endtask

  task automatic t_first_stage();
    wr(word(7'h15, 1'b1, 8'd5));
    check("R9 first write any key", count, 5);
    check("R1 count field load", count, 5);
    ticks(4);
    check("R7 four ticks", count, 1);
    repeat (3) @(negedge clk);
    check("R7 idle hold", count, 1);
    check("R5 no nmi before expiry", nmi, 0);
    ticks(1);
    check("R5 nmi raised", nmi, 1);
    check("R5 grace reload", count, 1);
    check("R5 no reset yet", rst_req, 0);
  endtask

  task automatic t_key_gate();
    wr(word(7'h15, 1'b1, 8'd9));
    check("R2 repeated key count", count, 1);
    check("R2 repeated key nmi", nmi, 1);
    wr(word(7'h6a, 1'b1, 8'd3));
    check("R4 service clears nmi", nmi, 0);
    check("R2 inverted key accepted", count, 3);
    wr(word(7'h15, 1'b1, 8'd0));
    check("R3 zero count is 256", count, 256);
    ticks(1);
    check("R7 tick from 256", count, 255);
  endtask

  task automatic t_stop();
    wr(word(7'h6a, 1'b0, 8'd4));
    check("R4 stop load", count, 4);
    ticks(3);
    check("R4 stopped holds", count, 4);
    check("R4 stopped no nmi", nmi, 0);
    wr(word(7'h00, 1'b1, 8'd6));
    check("R2 stopped accepts any key", count, 6);
  endtask

  task automatic t_escalate();
    wr(word(7'h7f, 1'b1, 8'd2));
    check("R1 reload 2", count, 2);
    ticks(2);
    check("R5 nmi on first expiry", nmi, 1);
    ticks(1);
    check("R6 reset request", rst_req, 1);
    check("R6 counter halted", count, 0);
    ticks(2);
    check("R6 halted stays 0", count, 0);
    wr(word(7'h00, 1'b1, 8'd5));
    check("R8 rst_req sticky", rst_req, 1);
    check("R4 nmi cleared", nmi, 0);
    check("R4 reload after fire", count, 5);
    do_reset();
    check("R8 cleared by reset", rst_req, 0);
    check("R9 count after reset", count, 0);
  endtask

  task automatic t_collision();
    wr(word(7'h33, 1'b1, 8'd1));
    check("R9 any key after reset", count, 1);
    @(negedge clk) begin wr_en = 1'b1; tick = 1'b1; wr_data = word(7'h4c, 1'b1, 8'd7); end
    @(negedge clk) begin wr_en = 1'b0; tick = 1'b0; end
    check("R10 write wins count", count, 7);
    check("R10 no nmi", nmi, 0);
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_first_stage();
    t_key_gate();
    t_stop();
    t_escalate();
    t_collision();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule